// File: doc/BRIEF.md
# Serial-Clocked Cartridge Address Generator

This block lives on the cartridge side of a host-to-storage link. The host has only a handful of control lines and a byte-wide data bus. From these lines the block builds the full byte address for a storage array of up to 128 KiB. It also selects what appears on the data bus during a read. The host steps through the array by toggling a serial clock line. The level of that line supplies the least significant address bit, and an internal counter advances on each falling edge.

A parameter selects one of three variants. The linear variant counts through the whole array. The paged variant adds a page counter that is stepped by its own strobe. The segmented variant adds a segment register on top of the paged scheme. The host loads that register from the data bus, and it picks one of eight 16 KiB windows. A master reset line clears the counters. When the identity option is fitted, raising the reset line during a read returns a fixed identity byte instead of array data.

All host lines are asynchronous to the block's system clock. Each line passes through a two-stage synchronizer, and every edge is detected against that clock. Reset wins over any edge seen in the same cycle.

Top module: `pack_addr_gen`

## Requirements
- R1: Address bit 0 follows the synchronized level of the serial clock line. A rising edge on that line changes only bit 0.
- R2: Each falling edge of the serial clock line, with reset low, advances the counter that drives address bits 1 and up by one. A full low-high-low cycle therefore moves the address by 2.
- R3: While master reset is high, the step counter and the page counter are held at zero, and an edge arriving in the same cycle is ignored. With the serial clock low, the address is then 0.
- R4: In the linear variant, the address wraps at the array size: 8192 full clock cycles on an 8 KiB array return it to 0.
- R5: In the paged variants, the step counter covers address bits 1 to 7 and wraps every 256 bytes without carrying into bit 8.
- R6: In the paged variants, a falling edge of the page strobe (active low) advances the page counter on bits 8 and up, and a rising edge does nothing. The page counter wraps at the array size in the paged variant and at 16 KiB in the segmented variant, so 64 pulses there return it to the start.
- R7: The segment register loads from the data bus on a rising edge of slot select (active low). It loads only while master reset is high, output enable (active low) is high and the page strobe is low. Slot-select edges under any other condition leave it unchanged, and master reset does not clear it.
- R8: In the segmented variant, address bits 16:14 are the low 3 bits of the segment register. Writing 8 selects segment 0 and writing 15 selects segment 7.
- R9: With the identity option fitted, a read with master reset high returns the byte 0x01. A read with master reset low returns the array byte at the current address.
- R10: The data-bus drive enable is high exactly when the synchronized slot select and output enable are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than any host line |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ln_step | input | 1 | Host serial clock line: level is address bit 0, falling edge steps |
| ln_clear | input | 1 | Host master reset line, active high |
| ln_page_n | input | 1 | Host page strobe, falling edge steps the page |
| ln_oe_n | input | 1 | Host output enable, active low |
| ln_sel_n | input | 1 | Host slot select, active low; rising edge may load the segment |
| bus_in | input | 8 | Data bus as driven by the host |
| mem_rdata | input | 8 | Byte read from the storage array at mem_addr |
| mem_addr | output | AW | Byte address into the storage array (17 bits by default) |
| bus_out | output | 8 | Byte to place on the data bus |
| bus_drive | output | 1 | High when bus_out should drive the data bus |

## Verification
The bench goes after counter wrap points. A design that carried from the step counter into the page bits would fail the 256-byte wrap. One that sized the page counter from the full array instead of the segment would fail the 64-pulse wrap. A linear counter one bit short would wrap at 4 KiB. Rising edges of the clock and page lines are driven on their own and checked for no advance, which catches a design that counts both edges. Segment writes are issued with each qualifying condition missing, and with values 8 and 15, to catch a design that loads too freely or keeps the fourth bit. Random sequences also change reset together with a clock fall, and issue reads with reset high. These expose a design where an edge beats reset, or where the identity byte leaks into normal reads.

// File: rtl/pack_addr_gen.sv
module pack_addr_gen #(
  parameter int unsigned MODE        = 2,
  parameter int unsigned ARRAY_BYTES = 131072,
  parameter bit          HAS_ID      = 1'b1,
  parameter logic [7:0]  ID_VALUE    = 8'h01,
  localparam int unsigned AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ln_step,
  input  logic          ln_clear,
  input  logic          ln_page_n,
  input  logic          ln_oe_n,
  input  logic          ln_sel_n,
  input  logic [7:0]    bus_in,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    bus_out,
  output logic          bus_drive
);

  localparam int unsigned CW = (MODE == 0) ? AW - 1 : 7;
  localparam int unsigned PW = (MODE == 0) ? 1 : ((MODE == 1) ? AW - 8 : 6);
  localparam int unsigned SW = (MODE == 2) ? AW - 14 : 1;
  localparam logic [4:0]  IDLE_LINES = 5'b11100;

  // line order: {sel_n, oe_n, page_n, clear, step}
  logic [4:0] s1_q, s2_q, last_q;
  logic [7:0] d1_q, d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= IDLE_LINES;
      s2_q   <= IDLE_LINES;
      last_q <= IDLE_LINES;
      d1_q   <= '0;
      d2_q   <= '0;
    end else begin
      s1_q   <= {ln_sel_n, ln_oe_n, ln_page_n, ln_clear, ln_step};
      s2_q   <= s1_q;
      last_q <= s2_q;
      d1_q   <= bus_in;
      d2_q   <= d1_q;
    end
  end

  logic step_s, clear_s, page_s, oe_s, sel_s;
  assign {sel_s, oe_s, page_s, clear_s, step_s} = s2_q;

  logic step_fall, page_fall, sel_rise;
  assign step_fall = last_q[0] & ~step_s;
  assign page_fall = last_q[2] & ~page_s;
  assign sel_rise  = ~last_q[4] & sel_s;

  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear_s)   cnt_q <= '0;
    else if (step_fall) cnt_q <= cnt_q + 1'b1;
  end

  logic [PW-1:0] page_q;
  logic [SW-1:0] seg_q;

  generate
    if (MODE == 0) begin : g_linear
      assign page_q   = '0;
      assign seg_q    = '0;
      assign mem_addr = {cnt_q, step_s};
    end else begin : g_paged
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         page_q <= '0;
        else if (clear_s)   page_q <= '0;
        else if (page_fall) page_q <= page_q + 1'b1;
      end
      if (MODE == 1) begin : g_flat
        assign seg_q    = '0;
        assign mem_addr = {page_q, cnt_q, step_s};
      end else begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) seg_q <= '0;
          else if (sel_rise && clear_s && oe_s && !page_s) seg_q <= d2_q[SW-1:0];
        end
        assign mem_addr = {seg_q, page_q, cnt_q, step_s};

        p_seg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (last_q[4] == sel_s) |=> $stable(seg_q));
        p_seg_clear_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (clear_s && !sel_rise) |=> $stable(seg_q));
      end

      p_page_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && !last_q[2] && page_s) |=> $stable(page_q));
      p_page_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_s |=> (page_q == '0));
    end
  endgenerate

  assign bus_drive = ~sel_s & ~oe_s;
  assign bus_out   = (HAS_ID && clear_s) ? ID_VALUE : mem_rdata;

  p_cnt_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_s |=> (cnt_q == '0));
  p_step_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_s && !last_q[0] && step_s) |=> $stable(cnt_q));
  p_step_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_s && step_fall) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_id_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_ID && bus_drive && clear_s) |-> (bus_out == ID_VALUE));
  p_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s2_q[0]) |-> mem_addr[0]);

endmodule

// File: tb/pack_addr_gen_tb.sv
`timescale 1ns/1ps
module pack_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic l_step = 1'b0, l_clear = 1'b0, l_page_n = 1'b1, l_oe_n = 1'b1, l_sel_n = 1'b1;
  logic [7:0] l_bus = 8'h00;

  logic [16:0] addr;
  logic [7:0]  rdata, bout;
  logic        bdrv;
  logic [12:0] lin_addr;
  logic [7:0]  lin_bout;
  logic        lin_bdrv;

  function automatic logic [7:0] memf(input logic [16:0] a);
    return a[7:0] ^ {a[16:9]} ^ 8'h5A;
  endfunction

  assign rdata = memf(addr);

  pack_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ln_step(l_step), .ln_clear(l_clear),
    .ln_page_n(l_page_n), .ln_oe_n(l_oe_n), .ln_sel_n(l_sel_n),
    .bus_in(l_bus), .mem_rdata(rdata), .mem_addr(addr),
    .bus_out(bout), .bus_drive(bdrv));

  pack_addr_gen #(.MODE(0), .ARRAY_BYTES(8192), .HAS_ID(1'b0)) dut_lin_i (
    .clk(clk), .rst_n(rst_n), .ln_step(l_step), .ln_clear(l_clear),
    .ln_page_n(l_page_n), .ln_oe_n(l_oe_n), .ln_sel_n(l_sel_n),
    .bus_in(l_bus), .mem_rdata(lin_addr[7:0]), .mem_addr(lin_addr),
    .bus_out(lin_bout), .bus_drive(lin_bdrv));

  int n_chk = 0, n_bad = 0;
  logic [6:0]  e_cnt = '0;
  logic [5:0]  e_pg  = '0;
  logic [2:0]  e_seg = '0;
  logic [11:0] e_lin = '0;

  function automatic logic [16:0] exp_addr();
    return {e_seg, e_pg, e_cnt, l_step};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic cl, input logic pg,
                       input logic oe, input logic se, input logic [7:0] d);
    logic o_st = l_step, o_pg = l_page_n, o_se = l_sel_n;
    l_step = st; l_clear = cl; l_page_n = pg; l_oe_n = oe; l_sel_n = se; l_bus = d;
    if (cl) begin
      e_cnt = '0; e_pg = '0; e_lin = '0;
    end else begin
      if (o_st && !st) begin e_cnt++; e_lin++; end
      if (o_pg && !pg) e_pg++;
    end
    if (!o_se && se && cl && oe && !pg) e_seg = d[2:0];
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all();
    chk("R1 R2 R3 R5 R6 R8 address", int'(addr), int'(exp_addr()));
    chk("R1 R2 R3 R4 linear address", int'(lin_addr), int'({e_lin, l_step}));
    chk("R10 drive enable", int'(bdrv), int'(!l_sel_n && !l_oe_n));
    if (!l_sel_n && !l_oe_n)
      chk("R9 read byte", int'(bout), l_clear ? 1 : int'(memf(exp_addr())));
  endtask

  task automatic seg_write(input logic [7:0] v);
    drive(l_step, 1'b1, 1'b0, 1'b1, 1'b1, v);
    drive(l_step, 1'b1, 1'b0, 1'b1, 1'b0, v);
    drive(l_step, 1'b1, 1'b0, 1'b1, 1'b1, v);
    drive(l_step, 1'b0, 1'b1, 1'b1, 1'b1, v);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset address", int'(addr), 0);
    chk("R10 reset drive", int'(bdrv), 0);

    // R1: rise changes bit 0 only; R2 fall steps by 2 total
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R1 rise gives addr 1", int'(addr), 1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R2 full cycle gives addr 2", int'(addr), 2);
    // R6: page rise does nothing, fall steps
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R6 page step", int'(addr), 17'h102);
    // R3: reset together with clock fall is ignored
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R3 reset beats edge", int'(addr), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);

    // R5: 256 cycles wrap low counter, no carry
    for (int i = 0; i < 256; i++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    end
    chk("R5 256-byte wrap", int'(addr), 0);

    // R6: 64 page pulses wrap within a segment
    for (int i = 0; i < 64; i++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    end
    chk("R6 segment page wrap", int'(addr), 0);

    // R7 R8: segment writes
    seg_write(8'h0F);
    chk("R8 write 15 -> segment 7", int'(addr), 17'h1C000);
    seg_write(8'h08);
    chk("R8 write 8 -> segment 0", int'(addr), 0);
    seg_write(8'h05);
    chk("R7 load 5", int'(addr), 17'h14000);
    // R7: missing conditions leave it unchanged
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h02);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h02);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h02);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h02);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h02);
    chk("R7 unqualified writes ignored, clear keeps segment", int'(addr), 17'h14000);

    // R9: identity read and normal read
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 id byte", int'(bout), 1);
    chk("R10 drive in read", int'(bdrv), 1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 array byte", int'(bout), int'(memf(exp_addr())));
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);

    // R4: linear wrap at 8 KiB
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    for (int i = 0; i < 8192; i++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
      if (i == 8191) chk("R4 linear top address", int'(lin_addr), 8191);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    end
    chk("R4 linear wrap to 0", int'(lin_addr), 0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic st = l_step, cl = l_clear, pg = l_page_n, oe = l_oe_n, se = l_sel_n;
      logic [7:0] d = l_bus;
      case ($urandom_range(0, 9))
        0, 1, 2, 3: st = ~st;
        4:          pg = ~pg;
        5:          cl = ($urandom_range(0, 3) == 0);
        6:          oe = ~oe;
        7:          se = ~se;
        8:          d = 8'($urandom);
        default: begin st = ~st; cl = $urandom_range(0, 1) == 1; end
      endcase
      drive(st, cl, pg, oe, se, d);
      check_all();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule